// File: doc/BRIEF.md
# Three-Wide Register Rename Stage

This stage takes a group of up to three micro-ops each clock, in program order, and rewrites their register operands into physical register tags. It keeps two front-end alias tables, one for integer architectural registers and one for floating-point data registers. Each table holds, for every architectural register, the physical register that will hold its newest value. A destination register is tagged with the physical register that the allocator already reserved for that micro-op, and the matching table entry is pointed at it. A source register is tagged with the newest mapping. That mapping comes from an older micro-op of the same group when one writes that register, and from the table otherwise. Operands that are memory locations, or absent, leave the stage with no tag.

Renamed micro-ops leave one clock later, with a queue-select bit: loads and stores go to the memory queue, and everything else goes to the general queue. Two writes to the same architectural register always land in different physical registers. The allocator guarantees this, so write-after-write hazards disappear. On a pipeline flush, a recovery input copies the retirement alias tables into the front-end tables. The group offered in that cycle is discarded.

Top module: `rn_rename3`

## Requirements
- R1: After reset, both tables map architectural register r to physical register r. All output valid bits are 0.
- R2: A group offered in cycle N appears on the outputs after the next rising clock edge. Each out_valid_o bit equals the corresponding uop_valid_i bit.
- R3: A valid micro-op with dst_reg_i=1 leaves with dst_tagged_o=1 and dst_tag_o equal to its dst_preg_i. The table entry of its class and dst_arch_i then holds that tag.
- R4: A register source with no older writer in the group is tagged with the table entry that has the same class as the micro-op (uop_fp_i: 0 integer, 1 FP) and the same architectural index.
- R5: A register source with an older writer in the group, of the same class and index, takes the dst_preg_i of the youngest such older slot (slot 0 is oldest).
- R6: A source with its reg flag 0 (memory or absent) leaves with tagged=0 and tag=0. A destination with dst_reg_i=0 leaves the same way.
- R7: When several slots of a group write the same class and index, the table keeps the youngest slot's tag.
- R8: out_mem_q_o equals uop_mem_i of the slot: 1 selects the memory queue, 0 the general queue.
- R9: Integer and FP tables are independent: a write in one class never changes a lookup in the other.
- R10: While flush_i=1, both tables load ret_int_map_i and ret_fp_map_i, and the group offered in that cycle is dropped, so its outputs are invalid next cycle.
- R11: An invalid slot writes no table entry, is never a bypass source, and leaves with every tagged bit and out_mem_q_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Load retirement maps, drop current group |
| ret_int_map_i | input | NUM_ARCH*PTAG_W | Retirement integer map, entry r at [r] |
| ret_fp_map_i | input | NUM_ARCH*PTAG_W | Retirement FP map |
| uop_valid_i | input | NUM_SLOTS | Slot holds a micro-op |
| uop_fp_i | input | NUM_SLOTS | Register class: 1 FP, 0 integer |
| uop_mem_i | input | NUM_SLOTS | Load or store |
| src_a_reg_i | input | NUM_SLOTS | Source A is a register |
| src_a_arch_i | input | NUM_SLOTS*AIDX_W | Source A architectural index |
| src_b_reg_i | input | NUM_SLOTS | Source B is a register |
| src_b_arch_i | input | NUM_SLOTS*AIDX_W | Source B architectural index |
| dst_reg_i | input | NUM_SLOTS | Destination is a register |
| dst_arch_i | input | NUM_SLOTS*AIDX_W | Destination architectural index |
| dst_preg_i | input | NUM_SLOTS*PTAG_W | Physical register reserved by the allocator |
| out_valid_o | output | NUM_SLOTS | Renamed slot valid |
| out_mem_q_o | output | NUM_SLOTS | 1 memory queue, 0 general queue |
| src_a_tagged_o | output | NUM_SLOTS | Source A carries a tag |
| src_a_tag_o | output | NUM_SLOTS*PTAG_W | Source A physical tag |
| src_b_tagged_o | output | NUM_SLOTS | Source B carries a tag |
| src_b_tag_o | output | NUM_SLOTS*PTAG_W | Source B physical tag |
| dst_tagged_o | output | NUM_SLOTS | Destination carries a tag |
| dst_tag_o | output | NUM_SLOTS*PTAG_W | Destination physical tag |

## Verification
The assertions take for granted that the allocator hands out distinct dst_preg_i values within a group. They also assume that every input is driven to a known value during and after reset. The bench draws reserved registers from a single wrapping counter, so tags in one group never collide and the reference model can tell bypass from table lookup. Flushes arrive with random retirement maps, and each is followed by a group that reads those maps back.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic {
    RC_INT = 1'b0,
    RC_FP  = 1'b1
  } reg_class_e;
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int NUM_ARCH = 8,
  parameter int PTAG_W   = 7,
  parameter int NUM_WR   = 3,
  parameter int NUM_RD   = 6,
  localparam int AIDX_W  = $clog2(NUM_ARCH)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 rec_en_i,
  input  logic [NUM_ARCH-1:0][PTAG_W-1:0]      rec_map_i,
  input  logic [NUM_WR-1:0]                    wr_en_i,
  input  logic [NUM_WR-1:0][AIDX_W-1:0]        wr_idx_i,
  input  logic [NUM_WR-1:0][PTAG_W-1:0]        wr_tag_i,
  input  logic [NUM_RD-1:0][AIDX_W-1:0]        rd_idx_i,
  output logic [NUM_RD-1:0][PTAG_W-1:0]        rd_tag_o
);
  logic [NUM_ARCH-1:0][PTAG_W-1:0] map_q, map_d;

  // older writes first so the youngest lands last
  always_comb begin
    map_d = map_q;
    if (rec_en_i) begin
      map_d = rec_map_i;
    end else begin
      for (int w = 0; w < NUM_WR; w++) begin
        if (wr_en_i[w]) map_d[wr_idx_i[w]] = wr_tag_i[w];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PTAG_W'(a);
    end else begin
      map_q <= map_d;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_tag_o[r] = map_q[rd_idx_i[r]];
  end

  AST_YOUNGEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_en_i && wr_en_i[NUM_WR-1]) |=> map_q[$past(wr_idx_i[NUM_WR-1])] == $past(wr_tag_i[NUM_WR-1])); // R7
  AST_RECOVER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_en_i |=> map_q == $past(rec_map_i)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_en_i && wr_en_i == '0) |=> $stable(map_q)); // R11
endmodule

// File: rtl/rn_src_resolve.sv
module rn_src_resolve #(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT      = 0,
  parameter int NUM_ARCH  = 8,
  parameter int PTAG_W    = 7,
  localparam int AIDX_W   = $clog2(NUM_ARCH)
) (
  input  logic                                  is_reg_i,
  input  rn_pkg::reg_class_e                    cls_i,
  input  logic [AIDX_W-1:0]                     arch_i,
  input  logic [PTAG_W-1:0]                     int_tag_i,
  input  logic [PTAG_W-1:0]                     fp_tag_i,
  input  logic [NUM_SLOTS-1:0]                  grp_wr_i,
  input  rn_pkg::reg_class_e [NUM_SLOTS-1:0]    grp_cls_i,
  input  logic [NUM_SLOTS-1:0][AIDX_W-1:0]      grp_arch_i,
  input  logic [NUM_SLOTS-1:0][PTAG_W-1:0]      grp_tag_i,
  output logic                                  tagged_o,
  output logic [PTAG_W-1:0]                     tag_o
);
  logic [PTAG_W-1:0] tag;

  // scan older slots oldest first; youngest match overrides
  always_comb begin
    tag = (cls_i == rn_pkg::RC_FP) ? fp_tag_i : int_tag_i;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (k < SLOT && grp_wr_i[k] && grp_cls_i[k] == cls_i && grp_arch_i[k] == arch_i)
        tag = grp_tag_i[k];
    end
  end

  assign tagged_o = is_reg_i;
  assign tag_o    = is_reg_i ? tag : '0;
endmodule

// File: rtl/rn_out_stage.sv
module rn_out_stage #(
  parameter int NUM_SLOTS = 3,
  parameter int PTAG_W    = 7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SLOTS-1:0]             valid_d_i,
  input  logic [NUM_SLOTS-1:0]             memq_d_i,
  input  logic [NUM_SLOTS-1:0]             a_tg_d_i,
  input  logic [NUM_SLOTS-1:0][PTAG_W-1:0] a_tag_d_i,
  input  logic [NUM_SLOTS-1:0]             b_tg_d_i,
  input  logic [NUM_SLOTS-1:0][PTAG_W-1:0] b_tag_d_i,
  input  logic [NUM_SLOTS-1:0]             d_tg_d_i,
  input  logic [NUM_SLOTS-1:0][PTAG_W-1:0] d_tag_d_i,
  output logic [NUM_SLOTS-1:0]             valid_o,
  output logic [NUM_SLOTS-1:0]             memq_o,
  output logic [NUM_SLOTS-1:0]             a_tg_o,
  output logic [NUM_SLOTS-1:0][PTAG_W-1:0] a_tag_o,
  output logic [NUM_SLOTS-1:0]             b_tg_o,
  output logic [NUM_SLOTS-1:0][PTAG_W-1:0] b_tag_o,
  output logic [NUM_SLOTS-1:0]             d_tg_o,
  output logic [NUM_SLOTS-1:0][PTAG_W-1:0] d_tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      memq_o  <= '0;
      a_tg_o  <= '0;
      a_tag_o <= '0;
      b_tg_o  <= '0;
      b_tag_o <= '0;
      d_tg_o  <= '0;
      d_tag_o <= '0;
    end else begin
      valid_o <= valid_d_i;
      memq_o  <= memq_d_i;
      a_tg_o  <= a_tg_d_i;
      a_tag_o <= a_tag_d_i;
      b_tg_o  <= b_tg_d_i;
      b_tag_o <= b_tag_d_i;
      d_tg_o  <= d_tg_d_i;
      d_tag_o <= d_tag_d_i;
    end
  end
endmodule

// File: rtl/rn_rename3.sv
module rn_rename3 #(
  parameter int NUM_SLOTS = 3,
  parameter int NUM_ARCH  = 8,
  parameter int NUM_PHYS  = 128,
  localparam int PTAG_W   = $clog2(NUM_PHYS),
  localparam int AIDX_W   = $clog2(NUM_ARCH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             flush_i,
  input  logic [NUM_ARCH-1:0][PTAG_W-1:0]  ret_int_map_i,
  input  logic [NUM_ARCH-1:0][PTAG_W-1:0]  ret_fp_map_i,
  input  logic [NUM_SLOTS-1:0]             uop_valid_i,
  input  logic [NUM_SLOTS-1:0]             uop_fp_i,
  input  logic [NUM_SLOTS-1:0]             uop_mem_i,
  input  logic [NUM_SLOTS-1:0]             src_a_reg_i,
  input  logic [NUM_SLOTS-1:0][AIDX_W-1:0] src_a_arch_i,
  input  logic [NUM_SLOTS-1:0]             src_b_reg_i,
  input  logic [NUM_SLOTS-1:0][AIDX_W-1:0] src_b_arch_i,
  input  logic [NUM_SLOTS-1:0]             dst_reg_i,
  input  logic [NUM_SLOTS-1:0][AIDX_W-1:0] dst_arch_i,
  input  logic [NUM_SLOTS-1:0][PTAG_W-1:0] dst_preg_i,
  output logic [NUM_SLOTS-1:0]             out_valid_o,
  output logic [NUM_SLOTS-1:0]             out_mem_q_o,
  output logic [NUM_SLOTS-1:0]             src_a_tagged_o,
  output logic [NUM_SLOTS-1:0][PTAG_W-1:0] src_a_tag_o,
  output logic [NUM_SLOTS-1:0]             src_b_tagged_o,
  output logic [NUM_SLOTS-1:0][PTAG_W-1:0] src_b_tag_o,
  output logic [NUM_SLOTS-1:0]             dst_tagged_o,
  output logic [NUM_SLOTS-1:0][PTAG_W-1:0] dst_tag_o
);
  localparam int NUM_RD = 2 * NUM_SLOTS;

  logic [NUM_SLOTS-1:0]               live, grp_wr, wr_int, wr_fp;
  rn_pkg::reg_class_e [NUM_SLOTS-1:0] cls;
  logic [NUM_RD-1:0][AIDX_W-1:0]      rd_idx;
  logic [NUM_RD-1:0][PTAG_W-1:0]      int_rd, fp_rd;
  logic [NUM_SLOTS-1:0]               a_tg_d, b_tg_d, d_tg_d, memq_d;
  logic [NUM_SLOTS-1:0][PTAG_W-1:0]   a_tag_d, b_tag_d, d_tag_d;

  assign live = uop_valid_i & ~{NUM_SLOTS{flush_i}};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign cls[s]        = rn_pkg::reg_class_e'(uop_fp_i[s]);
    assign grp_wr[s]     = live[s] & dst_reg_i[s];
    assign wr_int[s]     = grp_wr[s] & (cls[s] == rn_pkg::RC_INT);
    assign wr_fp[s]      = grp_wr[s] & (cls[s] == rn_pkg::RC_FP);
    assign rd_idx[2*s]   = src_a_arch_i[s];
    assign rd_idx[2*s+1] = src_b_arch_i[s];
    assign memq_d[s]     = live[s] & uop_mem_i[s];
    assign d_tg_d[s]     = grp_wr[s];
    assign d_tag_d[s]    = grp_wr[s] ? dst_preg_i[s] : '0;

    rn_src_resolve #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT(s), .NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W)
    ) u_res_a (
      .is_reg_i  (live[s] & src_a_reg_i[s]),
      .cls_i     (cls[s]),
      .arch_i    (src_a_arch_i[s]),
      .int_tag_i (int_rd[2*s]),
      .fp_tag_i  (fp_rd[2*s]),
      .grp_wr_i  (grp_wr),
      .grp_cls_i (cls),
      .grp_arch_i(dst_arch_i),
      .grp_tag_i (dst_preg_i),
      .tagged_o  (a_tg_d[s]),
      .tag_o     (a_tag_d[s])
    );

    rn_src_resolve #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT(s), .NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W)
    ) u_res_b (
      .is_reg_i  (live[s] & src_b_reg_i[s]),
      .cls_i     (cls[s]),
      .arch_i    (src_b_arch_i[s]),
      .int_tag_i (int_rd[2*s+1]),
      .fp_tag_i  (fp_rd[2*s+1]),
      .grp_wr_i  (grp_wr),
      .grp_cls_i (cls),
      .grp_arch_i(dst_arch_i),
      .grp_tag_i (dst_preg_i),
      .tagged_o  (b_tg_d[s]),
      .tag_o     (b_tag_d[s])
    );

    AST_DST_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uop_valid_i[s] && !flush_i && dst_reg_i[s]) |=>
        (dst_tagged_o[s] && dst_tag_o[s] == $past(dst_preg_i[s]))); // R3
    AST_SRC_UNTAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uop_valid_i[s] && !flush_i && !src_a_reg_i[s]) |=>
        (!src_a_tagged_o[s] && src_a_tag_o[s] == '0)); // R6
    AST_QUEUE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uop_valid_i[s] && !flush_i) |=> (out_mem_q_o[s] == $past(uop_mem_i[s]))); // R8
    AST_DEAD_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_valid_o[s] |-> !(dst_tagged_o[s] | src_a_tagged_o[s] | src_b_tagged_o[s] | out_mem_q_o[s])); // R11
  end

  if (NUM_SLOTS > 1) begin : g_byp_chk
    AST_BYPASS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flush_i && uop_valid_i[0] && uop_valid_i[1] && dst_reg_i[0] && src_a_reg_i[1] &&
       uop_fp_i[0] == uop_fp_i[1] && dst_arch_i[0] == src_a_arch_i[1]) |=>
        (src_a_tag_o[1] == $past(dst_preg_i[0]))); // R5
  end

  rn_alias_table #(
    .NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W), .NUM_WR(NUM_SLOTS), .NUM_RD(NUM_RD)
  ) u_int_tab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rec_en_i (flush_i),
    .rec_map_i(ret_int_map_i),
    .wr_en_i  (wr_int),
    .wr_idx_i (dst_arch_i),
    .wr_tag_i (dst_preg_i),
    .rd_idx_i (rd_idx),
    .rd_tag_o (int_rd)
  );

  rn_alias_table #(
    .NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W), .NUM_WR(NUM_SLOTS), .NUM_RD(NUM_RD)
  ) u_fp_tab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rec_en_i (flush_i),
    .rec_map_i(ret_fp_map_i),
    .wr_en_i  (wr_fp),
    .wr_idx_i (dst_arch_i),
    .wr_tag_i (dst_preg_i),
    .rd_idx_i (rd_idx),
    .rd_tag_o (fp_rd)
  );

  rn_out_stage #(.NUM_SLOTS(NUM_SLOTS), .PTAG_W(PTAG_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_d_i(live),
    .memq_d_i (memq_d),
    .a_tg_d_i (a_tg_d),
    .a_tag_d_i(a_tag_d),
    .b_tg_d_i (b_tg_d),
    .b_tag_d_i(b_tag_d),
    .d_tg_d_i (d_tg_d),
    .d_tag_d_i(d_tag_d),
    .valid_o  (out_valid_o),
    .memq_o   (out_mem_q_o),
    .a_tg_o   (src_a_tagged_o),
    .a_tag_o  (src_a_tag_o),
    .b_tg_o   (src_b_tagged_o),
    .b_tag_o  (src_b_tag_o),
    .d_tg_o   (dst_tagged_o),
    .d_tag_o  (dst_tag_o)
  );

  AST_FLUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (out_valid_o == '0)); // R10
endmodule

// File: tb/rn_rename3_tb_top.sv
`timescale 1ns/1ps
module rn_rename3_tb_top;
  localparam int NS = 3, NA = 8, NP = 128, PW = 7, AW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, flush;
  logic [NA-1:0][PW-1:0] ret_int, ret_fp;
  logic [NS-1:0] v, fp, mem, a_reg, b_reg, d_reg;
  logic [NS-1:0][AW-1:0] a_arch, b_arch, d_arch;
  logic [NS-1:0][PW-1:0] d_preg;
  logic [NS-1:0] o_v, o_mq, o_at, o_bt, o_dt;
  logic [NS-1:0][PW-1:0] o_atag, o_btag, o_dtag;

  rn_rename3 #(.NUM_SLOTS(NS), .NUM_ARCH(NA), .NUM_PHYS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ret_int_map_i(ret_int), .ret_fp_map_i(ret_fp),
    .uop_valid_i(v), .uop_fp_i(fp), .uop_mem_i(mem),
    .src_a_reg_i(a_reg), .src_a_arch_i(a_arch),
    .src_b_reg_i(b_reg), .src_b_arch_i(b_arch),
    .dst_reg_i(d_reg), .dst_arch_i(d_arch), .dst_preg_i(d_preg),
    .out_valid_o(o_v), .out_mem_q_o(o_mq),
    .src_a_tagged_o(o_at), .src_a_tag_o(o_atag),
    .src_b_tagged_o(o_bt), .src_b_tag_o(o_btag),
    .dst_tagged_o(o_dt), .dst_tag_o(o_dtag)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // staged stimulus
  bit st_flush;
  bit [NS-1:0] st_v, st_fp, st_mem, st_ar, st_br, st_dr;
  int st_aa[NS], st_ba[NS], st_da[NS], st_pr[NS];
  int st_ri[NA], st_rf[NA];
  int next_preg = 8;

  // reference model
  int tab[2][NA];
  bit have_exp;
  bit e_v[NS], e_mq[NS];
  int e_a[NS], e_b[NS], e_d[NS];   // {tagged,tag} packed as tagged*256+tag
  string e_vreq[NS], e_areq[NS], e_breq[NS];
  string src_req = "R4";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pk(bit t, int tag);
    return t ? 256 + tag : 0;
  endfunction

  task automatic compare();
    if (!have_exp) return;
    for (int s = 0; s < NS; s++) begin
      chk(o_v[s] == e_v[s], e_vreq[s], $sformatf("valid s%0d", s), o_v[s], e_v[s]);
      chk(o_mq[s] == e_mq[s], "R8", $sformatf("memq s%0d", s), o_mq[s], e_mq[s]);
      chk(pk(o_at[s], o_atag[s]) == e_a[s], e_areq[s], $sformatf("srcA s%0d", s), pk(o_at[s], o_atag[s]), e_a[s]);
      chk(pk(o_bt[s], o_btag[s]) == e_b[s], e_breq[s], $sformatf("srcB s%0d", s), pk(o_bt[s], o_btag[s]), e_b[s]);
      chk(pk(o_dt[s], o_dtag[s]) == e_d[s], "R3", $sformatf("dst s%0d", s), pk(o_dt[s], o_dtag[s]), e_d[s]);
    end
  endtask

  task automatic model();
    bit wrote[2][NA];
    for (int c = 0; c < 2; c++) for (int a = 0; a < NA; a++) wrote[c][a] = 0;
    for (int s = 0; s < NS; s++) begin
      e_v[s] = 0; e_mq[s] = 0; e_a[s] = 0; e_b[s] = 0; e_d[s] = 0;
      e_vreq[s] = st_flush ? "R10" : (st_v[s] ? "R2" : "R11");
      e_areq[s] = e_vreq[s]; e_breq[s] = e_vreq[s];
    end
    if (st_flush) begin
      for (int a = 0; a < NA; a++) begin tab[0][a] = st_ri[a]; tab[1][a] = st_rf[a]; end
    end else begin
      for (int s = 0; s < NS; s++) begin
        int c;
        if (!st_v[s]) continue;
        c = st_fp[s];
        e_v[s] = 1; e_mq[s] = st_mem[s];
        if (st_ar[s]) begin
          e_a[s] = 256 + tab[c][st_aa[s]];
          e_areq[s] = wrote[c][st_aa[s]] ? "R5" : src_req;
        end else e_areq[s] = "R6";
        if (st_br[s]) begin
          e_b[s] = 256 + tab[c][st_ba[s]];
          e_breq[s] = wrote[c][st_ba[s]] ? "R5" : src_req;
        end else e_breq[s] = "R6";
        if (st_dr[s]) begin
          e_d[s] = 256 + st_pr[s];
          tab[c][st_da[s]] = st_pr[s];
          wrote[c][st_da[s]] = 1;
        end
      end
    end
    have_exp = 1;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    flush = st_flush;
    for (int a = 0; a < NA; a++) begin ret_int[a] = PW'(st_ri[a]); ret_fp[a] = PW'(st_rf[a]); end
    for (int s = 0; s < NS; s++) begin
      v[s] = st_v[s]; fp[s] = st_fp[s]; mem[s] = st_mem[s];
      a_reg[s] = st_ar[s]; b_reg[s] = st_br[s]; d_reg[s] = st_dr[s];
      a_arch[s] = AW'(st_aa[s]); b_arch[s] = AW'(st_ba[s]); d_arch[s] = AW'(st_da[s]);
      d_preg[s] = PW'(st_pr[s]);
    end
    model();
  endtask

  task automatic clear_grp();
    st_flush = 0;
    for (int s = 0; s < NS; s++) begin
      st_v[s] = 0; st_fp[s] = 0; st_mem[s] = 0; st_ar[s] = 0; st_br[s] = 0; st_dr[s] = 0;
      st_aa[s] = 0; st_ba[s] = 0; st_da[s] = 0; st_pr[s] = 0;
    end
  endtask

  task automatic set_slot(int s, bit f, bit m, bit ar, int aa, bit br, int ba, bit dr, int da);
    st_v[s] = 1; st_fp[s] = f; st_mem[s] = m;
    st_ar[s] = ar; st_aa[s] = aa; st_br[s] = br; st_ba[s] = ba;
    st_dr[s] = dr; st_da[s] = da;
    st_pr[s] = next_preg;
    if (dr) next_preg = (next_preg + 1) % NP;
  endtask

  initial begin
    rst_n = 0; flush = 0; v = '0; fp = '0; mem = '0; a_reg = '0; b_reg = '0; d_reg = '0;
    a_arch = '0; b_arch = '0; d_arch = '0; d_preg = '0; ret_int = '0; ret_fp = '0;
    have_exp = 0;
    for (int a = 0; a < NA; a++) begin st_ri[a] = 0; st_rf[a] = 0; end
    clear_grp();
    repeat (3) @(negedge clk);
    chk(o_v == '0 && o_dt == '0 && o_at == '0, "R1", "outputs in reset", int'(o_v), 0);
    rst_n = 1;
    for (int c = 0; c < 2; c++) for (int a = 0; a < NA; a++) tab[c][a] = a;

    // R1: identity map read back
    src_req = "R1";
    clear_grp();
    set_slot(0, 0, 0, 1, 0, 1, 1, 0, 0);
    set_slot(1, 1, 0, 1, 2, 1, 3, 0, 0);
    set_slot(2, 0, 1, 1, 7, 1, 6, 0, 0);
    step();

    // R3/R5/R7: three writers of int reg 2 with chained reads
    src_req = "R4";
    clear_grp();
    set_slot(0, 0, 0, 1, 2, 0, 0, 1, 2);
    set_slot(1, 0, 1, 1, 2, 1, 4, 1, 2);
    set_slot(2, 0, 0, 1, 2, 0, 0, 1, 2);
    step();
    src_req = "R7";
    clear_grp();
    set_slot(0, 0, 0, 1, 2, 1, 2, 0, 0);
    step();

    // R9: FP write of index 2 must not disturb the integer mapping
    src_req = "R9";
    clear_grp();
    set_slot(0, 1, 0, 0, 0, 0, 0, 1, 2);
    set_slot(2, 0, 0, 1, 2, 0, 0, 0, 0);
    step();
    clear_grp();
    set_slot(0, 0, 0, 1, 2, 0, 0, 0, 0);
    set_slot(1, 1, 0, 1, 2, 0, 0, 0, 0);
    step();

    // R11: invalid writer in slot 0 must not bypass or update
    src_req = "R11";
    clear_grp();
    set_slot(0, 0, 0, 0, 0, 0, 0, 1, 5);
    st_v[0] = 0;
    set_slot(1, 0, 0, 1, 5, 0, 0, 0, 0);
    step();
    clear_grp();
    set_slot(0, 0, 0, 1, 5, 0, 0, 0, 0);
    step();

    // R10: flush with a live group, then read maps back
    clear_grp();
    for (int a = 0; a < NA; a++) begin st_ri[a] = 100 + a; st_rf[a] = 60 + a; end
    st_flush = 1;
    set_slot(0, 0, 0, 1, 1, 0, 0, 1, 1);
    step();
    src_req = "R10";
    clear_grp();
    set_slot(0, 0, 0, 1, 1, 1, 3, 0, 0);
    set_slot(1, 1, 0, 1, 1, 1, 7, 0, 0);
    step();

    // random traffic
    src_req = "R4";
    for (int n = 0; n < 3000; n++) begin
      clear_grp();
      for (int s = 0; s < NS; s++) begin
        if ($urandom_range(0, 9) < 8)
          set_slot(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
                   1'($urandom_range(0, 3) != 0), $urandom_range(0, NA-1),
                   1'($urandom_range(0, 3) != 0), $urandom_range(0, NA-1),
                   1'($urandom_range(0, 3) != 0), $urandom_range(0, NA-1));
      end
      if ($urandom_range(0, 49) == 0) begin
        st_flush = 1;
        for (int a = 0; a < NA; a++) begin st_ri[a] = $urandom_range(0, NP-1); st_rf[a] = $urandom_range(0, NP-1); end
      end
      step();
    end
    clear_grp();
    step();
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule